// File: doc/BRIEF.md
# SDRAM Command Sequencer for Two Chip-Select Spaces

This block turns single requests from an internal bus port into command sequences for synchronous DRAM. Up to two chip-select spaces can hold SDRAM. Both spaces share one set of RAS, CAS and WE lines, one address bus and four byte-lane DQM strobes. Each space has its own chip select, and only the selected devices take notice of a command.

A 3-bit memory-enable setting decides which space is SDRAM. A width setting picks a 16-bit or a 32-bit data path, and this fixes the burst length. A burst-write setting decides whether writes move one beat or a whole burst. Every access opens a row and then issues the auto-precharge form of read or write. The block marks the cycles in which read data is due or write data must be driven. Auto-refresh requests and self-refresh entry and exit are handled between accesses. A mode-register-set request writes a value to the SDRAM mode register.

Top module: `sdram_cmd_ctrl`

## Requirements
- R1: The memory-enable field maps spaces as follows: 001 makes only space 1 SDRAM, 100 makes only space 0 SDRAM, 101 makes both SDRAM, and every other value makes neither. An access request to a space that is not SDRAM is accepted and then dropped. It issues no command, and both chip selects (`sd_cs_n`, bit 0 for space 0) stay high.
- R2: An accepted access shows ACTV ({RAS,CAS,WE} = 011) with the row and bank in the first cycle after acceptance, on that space's chip select only. Exactly two cycles later it shows READ (101) or WRIT (100). In that cycle the column is on the low address bits and address bit 10 is high, which selects auto-precharge.
- R3: Read data is flagged on `rd_valid` starting two cycles after the read command.
- R4: A read always bursts: 8 consecutive `rd_valid` cycles when `cfg_wide`=0 (16-bit), 4 when `cfg_wide`=1 (32-bit).
- R5: With `cfg_burst_wr`=0 a write has exactly one `wr_beat` cycle, in the write-command cycle. With `cfg_burst_wr`=1 it has a full burst of 8 or 4 cycles, starting in the same cycle.
- R6: `sd_dqm` is active low. In 32-bit mode, `req_be[i]` (byte address 4n+i) drives `sd_dqm[3-i]`, so `sd_dqm[3]` serves byte 4n and `sd_dqm[0]` serves 4n+3. Reads enable all four lanes.
- R7: In 16-bit mode, `sd_dqm[3:2]` stay high. `req_be[0]` drives `sd_dqm[1]` and `req_be[1]` drives `sd_dqm[0]`, and reads enable the two lower lanes.
- R8: Outside data cycles, `sd_dqm` is 1111. In cycles with neither a command nor data, both chip selects are high.
- R9: A refresh request is held pending, and it drops `req_ready` from the next cycle. When idle, the block first issues precharge-all (010, address bit 10 high) on every SDRAM space. Two cycles later it issues auto-refresh (001) with CKE high. `req_ready` returns four cycles after the refresh command.
- R10: While `self_req` is high and the block is idle, it issues precharge-all and, two cycles later, the refresh code with `sd_cke` going low in the same cycle. `sd_cke` stays low and the chip selects stay high until `self_req` falls. The cycle after that, `sd_cke` is high again, and `req_ready` returns four cycles after `sd_cke` rises.
- R11: A request with `req_op`=2 issues MRS (000) in the first cycle after acceptance. The command goes to every SDRAM space, with `req_row` on the address bus.
- R12: After reset, both chip selects are high, `sd_cke` is high, `sd_dqm` is 1111, both data strobes are low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mem_en | input | 3 | Space mapping field |
| cfg_wide | input | 1 | 1 = 32-bit data path, 0 = 16-bit |
| cfg_burst_wr | input | 1 | 1 = writes burst, 0 = single writes |
| req_valid | input | 1 | Request present |
| req_op | input | 2 | 0 read, 1 write, 2 mode-register set |
| req_space | input | 1 | Target chip-select space |
| req_bank | input | BANK_W | Bank address |
| req_row | input | ADDR_W | Row address, or mode value |
| req_col | input | COL_W | Column address |
| req_be | input | 4 | Byte enables, bit i = byte 4n+i |
| req_ready | output | 1 | Request accepted on this edge if valid |
| refresh_req | input | 1 | Auto-refresh request pulse |
| self_req | input | 1 | Self-refresh level |
| sd_cke | output | 1 | Clock enable |
| sd_cs_n | output | 2 | Chip selects, bit 0 = space 0 |
| sd_ras_n | output | 1 | Row strobe |
| sd_cas_n | output | 1 | Column strobe |
| sd_we_n | output | 1 | Write enable |
| sd_ba | output | BANK_W | Bank address |
| sd_addr | output | ADDR_W | Address bus |
| sd_dqm | output | 4 | Byte-lane masks, active low |
| rd_valid | output | 1 | Read data due this cycle |
| wr_beat | output | 1 | Write data driven this cycle |

## Verification
All outputs are registered, so the first visible effect of an accepted request is in the cycle after the accepting edge, called k0. Within an access, ACTV is due at k0, the column command at k2, read data from k4, and write beats from k2. For refresh and self-refresh, precharge-all is due one cycle after the request is seen, and the refresh code two cycles after that. The bench drives on falling edges and records every output once per cycle on the falling edge, indexed from k0. Each check compares a fixed index of that record against the value the requirement predicts.

// File: rtl/sdram_cmd_pkg.sv
package sdram_cmd_pkg;
  // {RAS#, CAS#, WE#}; the chip select completes the command
  typedef enum logic [2:0] {
    CMD_MRS = 3'b000,
    CMD_REF = 3'b001,
    CMD_PRE = 3'b010,
    CMD_ACT = 3'b011,
    CMD_WR  = 3'b100,
    CMD_RD  = 3'b101,
    CMD_NOP = 3'b111
  } sd_cmd_e;

  typedef enum logic [2:0] {
    S_IDLE, S_RCD, S_CL, S_BURST, S_PRE, S_SELF, S_WAIT
  } seq_state_e;
endpackage

// File: rtl/sdram_space_map.sv
module sdram_space_map (
  input  logic [2:0] mem_en,
  output logic [1:0] sd_mask
);
  always_comb begin
    case (mem_en)
      3'b001:  sd_mask = 2'b10;
      3'b100:  sd_mask = 2'b01;
      3'b101:  sd_mask = 2'b11;
      default: sd_mask = 2'b00;
    endcase
  end
endmodule

// File: rtl/sdram_lane_mask.sv
module sdram_lane_mask #(
  parameter int LANES = 4
) (
  input  logic             wide,
  input  logic [LANES-1:0] be,
  output logic [LANES-1:0] wr_dqm,
  output logic [LANES-1:0] rd_dqm
);
  localparam int HALF = LANES / 2;

  logic [LANES-1:0] wide_m;
  logic [LANES-1:0] nar_m;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    // lowest byte address sits on the most significant strobe
    assign wide_m[LANES-1-i] = ~be[i];
    if (i < HALF) begin : g_low
      assign nar_m[HALF-1-i] = ~be[i];
    end else begin : g_high
      assign nar_m[i] = 1'b1;
    end
  end

  assign wr_dqm = wide ? wide_m : nar_m;
  assign rd_dqm = wide ? '0 : {{HALF{1'b1}}, {HALF{1'b0}}};
endmodule

// File: rtl/sdram_seq.sv
module sdram_seq
  import sdram_cmd_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int COL_W     = 9,
  parameter int BANK_W    = 2,
  parameter int LANES     = 4,
  parameter int T_RCD     = 2,
  parameter int T_CL      = 2,
  parameter int T_RP      = 2,
  parameter int T_RC      = 4,
  parameter int T_MRD     = 2,
  parameter int T_XSR     = 4,
  parameter int BL_WIDE   = 4,
  parameter int BL_NARROW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        sd_mask,
  input  logic              wide,
  input  logic              burst_wr,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic              req_space,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ADDR_W-1:0] req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic [LANES-1:0]  wr_dqm,
  input  logic [LANES-1:0]  rd_dqm,
  input  logic              refresh_req,
  input  logic              self_req,
  output logic              req_ready,
  output logic              sd_cke,
  output logic [1:0]        sd_cs_n,
  output sd_cmd_e           sd_cmd,
  output logic [BANK_W-1:0] sd_ba,
  output logic [ADDR_W-1:0] sd_addr,
  output logic [LANES-1:0]  sd_dqm,
  output logic              rd_valid,
  output logic              wr_beat
);
  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int MAX_T = imax(imax(imax(T_RCD, T_CL), imax(T_RP, T_RC)),
                              imax(imax(T_MRD, T_XSR), imax(BL_WIDE, BL_NARROW)));
  localparam int CNT_W = $clog2(MAX_T + 1);
  localparam logic [ADDR_W-1:0] AP_BIT = ADDR_W'(1) << 10;

  seq_state_e        state;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  nb_m1;
  logic              ref_pend;
  logic              go_self;
  logic              op_wr;
  logic [1:0]        sel_q;
  logic [COL_W-1:0]  col_q;
  logic [LANES-1:0]  wdqm_q;
  logic [LANES-1:0]  rdqm_q;

  assign req_ready = (state == S_IDLE) && !ref_pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      cnt      <= '0;
      nb_m1    <= '0;
      ref_pend <= 1'b0;
      go_self  <= 1'b0;
      op_wr    <= 1'b0;
      sel_q    <= '0;
      col_q    <= '0;
      wdqm_q   <= '1;
      rdqm_q   <= '1;
      sd_cke   <= 1'b1;
      sd_cs_n  <= '1;
      sd_cmd   <= CMD_NOP;
      sd_ba    <= '0;
      sd_addr  <= '0;
      sd_dqm   <= '1;
      rd_valid <= 1'b0;
      wr_beat  <= 1'b0;
    end else begin
      sd_cmd   <= CMD_NOP;
      sd_cs_n  <= '1;
      sd_dqm   <= '1;
      rd_valid <= 1'b0;
      wr_beat  <= 1'b0;
      case (state)
        S_IDLE: begin
          if (ref_pend || (!req_valid && self_req)) begin
            sd_cmd  <= CMD_PRE;
            sd_cs_n <= ~sd_mask;
            sd_addr <= AP_BIT;
            go_self <= !ref_pend;
            cnt     <= CNT_W'(T_RP - 1);
            state   <= S_PRE;
          end else if (req_valid) begin
            if (req_op[1]) begin
              sd_cmd  <= CMD_MRS;
              sd_cs_n <= ~sd_mask;
              sd_addr <= req_row;
              sd_ba   <= '0;
              cnt     <= CNT_W'(T_MRD - 1);
              state   <= S_WAIT;
            end else if (sd_mask[req_space]) begin
              sd_cmd  <= CMD_ACT;
              sd_cs_n <= req_space ? 2'b01 : 2'b10;
              sel_q   <= req_space ? 2'b10 : 2'b01;
              sd_addr <= req_row;
              sd_ba   <= req_bank;
              col_q   <= req_col;
              op_wr   <= req_op[0];
              wdqm_q  <= wr_dqm;
              rdqm_q  <= rd_dqm;
              if (req_op[0] && !burst_wr) nb_m1 <= '0;
              else nb_m1 <= wide ? CNT_W'(BL_WIDE - 1) : CNT_W'(BL_NARROW - 1);
              cnt     <= CNT_W'(T_RCD - 1);
              state   <= S_RCD;
            end
          end
        end
        S_RCD: begin
          if (cnt != '0) cnt <= cnt - 1'b1;
          else begin
            sd_cs_n <= ~sel_q;
            sd_addr <= AP_BIT | {{(ADDR_W-COL_W){1'b0}}, col_q};
            if (op_wr) begin
              sd_cmd  <= CMD_WR;
              sd_dqm  <= wdqm_q;
              wr_beat <= 1'b1;
              cnt     <= nb_m1;
              state   <= S_BURST;
            end else begin
              sd_cmd <= CMD_RD;
              cnt    <= CNT_W'(T_CL - 1);
              state  <= S_CL;
            end
          end
        end
        S_CL: begin
          if (cnt != '0) cnt <= cnt - 1'b1;
          else begin
            sd_cs_n  <= ~sel_q;
            sd_dqm   <= rdqm_q;
            rd_valid <= 1'b1;
            cnt      <= nb_m1;
            state    <= S_BURST;
          end
        end
        S_BURST: begin
          if (cnt != '0) begin
            sd_cs_n  <= ~sel_q;
            sd_dqm   <= op_wr ? wdqm_q : rdqm_q;
            rd_valid <= !op_wr;
            wr_beat  <= op_wr;
            cnt      <= cnt - 1'b1;
          end else begin
            cnt   <= CNT_W'(T_RP - 1);
            state <= S_WAIT;
          end
        end
        S_PRE: begin
          if (cnt != '0) cnt <= cnt - 1'b1;
          else begin
            sd_cmd  <= CMD_REF;
            sd_cs_n <= ~sd_mask;
            if (go_self) begin
              sd_cke <= 1'b0;
              state  <= S_SELF;
            end else begin
              ref_pend <= 1'b0;
              cnt      <= CNT_W'(T_RC - 1);
              state    <= S_WAIT;
            end
          end
        end
        S_SELF: begin
          if (!self_req) begin
            sd_cke <= 1'b1;
            cnt    <= CNT_W'(T_XSR - 1);
            state  <= S_WAIT;
          end
        end
        S_WAIT: begin
          if (cnt != '0) cnt <= cnt - 1'b1;
          else state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
      if (refresh_req) ref_pend <= 1'b1;
    end
  end

  // R10
  cke_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(sd_cke) |-> (sd_cmd == CMD_REF));

  // R10
  self_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!sd_cke && $past(!sd_cke)) |-> (sd_cs_n == 2'b11));

  // R8
  dqm_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (sd_dqm != '1) |-> (rd_valid || wr_beat));

  // R2
  access_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    (sd_cmd == CMD_ACT || sd_cmd == CMD_RD || sd_cmd == CMD_WR) |-> ($countones(~sd_cs_n) == 1));
endmodule

// File: rtl/sdram_cmd_ctrl.sv
module sdram_cmd_ctrl
  import sdram_cmd_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int COL_W     = 9,
  parameter int BANK_W    = 2,
  parameter int T_RCD     = 2,
  parameter int T_CL      = 2,
  parameter int T_RP      = 2,
  parameter int T_RC      = 4,
  parameter int T_MRD     = 2,
  parameter int T_XSR     = 4,
  parameter int BL_WIDE   = 4,
  parameter int BL_NARROW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        cfg_mem_en,
  input  logic              cfg_wide,
  input  logic              cfg_burst_wr,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic              req_space,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ADDR_W-1:0] req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic [3:0]        req_be,
  output logic              req_ready,
  input  logic              refresh_req,
  input  logic              self_req,
  output logic              sd_cke,
  output logic [1:0]        sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [BANK_W-1:0] sd_ba,
  output logic [ADDR_W-1:0] sd_addr,
  output logic [3:0]        sd_dqm,
  output logic              rd_valid,
  output logic              wr_beat
);
  logic [1:0] map_mask;
  logic [3:0] wr_dqm;
  logic [3:0] rd_dqm;
  sd_cmd_e    cmd;

  sdram_space_map u_map (
    .mem_en  (cfg_mem_en),
    .sd_mask (map_mask)
  );

  sdram_lane_mask #(.LANES(4)) u_lane (
    .wide   (cfg_wide),
    .be     (req_be),
    .wr_dqm (wr_dqm),
    .rd_dqm (rd_dqm)
  );

  sdram_seq #(
    .ADDR_W(ADDR_W), .COL_W(COL_W), .BANK_W(BANK_W), .LANES(4),
    .T_RCD(T_RCD), .T_CL(T_CL), .T_RP(T_RP), .T_RC(T_RC),
    .T_MRD(T_MRD), .T_XSR(T_XSR), .BL_WIDE(BL_WIDE), .BL_NARROW(BL_NARROW)
  ) u_seq (
    .clk         (clk),
    .rst         (rst),
    .sd_mask     (map_mask),
    .wide        (cfg_wide),
    .burst_wr    (cfg_burst_wr),
    .req_valid   (req_valid),
    .req_op      (req_op),
    .req_space   (req_space),
    .req_bank    (req_bank),
    .req_row     (req_row),
    .req_col     (req_col),
    .wr_dqm      (wr_dqm),
    .rd_dqm      (rd_dqm),
    .refresh_req (refresh_req),
    .self_req    (self_req),
    .req_ready   (req_ready),
    .sd_cke      (sd_cke),
    .sd_cs_n     (sd_cs_n),
    .sd_cmd      (cmd),
    .sd_ba       (sd_ba),
    .sd_addr     (sd_addr),
    .sd_dqm      (sd_dqm),
    .rd_valid    (rd_valid),
    .wr_beat     (wr_beat)
  );

  assign {sd_ras_n, sd_cas_n, sd_we_n} = cmd;

  // R1
  cs_map_chk: assert property (@(posedge clk) disable iff (rst)
    (sd_cs_n != 2'b11 && $stable(cfg_mem_en)) |-> ((~sd_cs_n & ~map_mask) == 2'b00));

  // R10
  ready_cke_chk: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> sd_cke);
endmodule

// File: tb/tb_sdram_cmd_ctrl.sv
`timescale 1ns/1ps
module tb_sdram_cmd_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  cfg_mem_en = 3'b000;
  logic        cfg_wide = 1'b0;
  logic        cfg_burst_wr = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_op = 2'd0;
  logic        req_space = 1'b0;
  logic [1:0]  req_bank = 2'd0;
  logic [11:0] req_row = '0;
  logic [8:0]  req_col = '0;
  logic [3:0]  req_be = 4'hF;
  logic        req_ready;
  logic        refresh_req = 1'b0;
  logic        self_req = 1'b0;
  logic        sd_cke, sd_ras_n, sd_cas_n, sd_we_n, rd_valid, wr_beat;
  logic [1:0]  sd_cs_n, sd_ba;
  logic [11:0] sd_addr;
  logic [3:0]  sd_dqm;

  int n_tests = 0;
  int n_fail  = 0;

  logic [2:0]  t_cmd [32];
  logic [1:0]  t_cs  [32];
  logic [11:0] t_addr[32];
  logic [1:0]  t_ba  [32];
  logic [3:0]  t_dqm [32];
  logic        t_rv  [32];
  logic        t_wb  [32];
  logic        t_cke [32];
  logic        t_rdy [32];

  always #2.5 clk = ~clk;

  sdram_cmd_ctrl dut (
    .clk(clk), .rst(rst), .cfg_mem_en(cfg_mem_en), .cfg_wide(cfg_wide),
    .cfg_burst_wr(cfg_burst_wr), .req_valid(req_valid), .req_op(req_op),
    .req_space(req_space), .req_bank(req_bank), .req_row(req_row),
    .req_col(req_col), .req_be(req_be), .req_ready(req_ready),
    .refresh_req(refresh_req), .self_req(self_req), .sd_cke(sd_cke),
    .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
    .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_addr(sd_addr), .sd_dqm(sd_dqm),
    .rd_valid(rd_valid), .wr_beat(wr_beat)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // record outputs at the current falling edge and the following n-1 ones
  task automatic capture(input int first, input int n);
    for (int k = 0; k < n; k++) begin
      t_cmd[first+k]  = {sd_ras_n, sd_cas_n, sd_we_n};
      t_cs[first+k]   = sd_cs_n;
      t_addr[first+k] = sd_addr;
      t_ba[first+k]   = sd_ba;
      t_dqm[first+k]  = sd_dqm;
      t_rv[first+k]   = rd_valid;
      t_wb[first+k]   = wr_beat;
      t_cke[first+k]  = sd_cke;
      t_rdy[first+k]  = req_ready;
      if (k < n - 1) @(negedge clk);
    end
  endtask

  task automatic issue(input logic [1:0] op, input logic sp, input logic [1:0] bank,
                       input logic [11:0] row, input logic [8:0] col, input logic [3:0] be);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_op = op; req_space = sp; req_bank = bank;
    req_row = row; req_col = col; req_be = be;
    @(negedge clk);
    req_valid = 1'b0;
    capture(0, 24);
  endtask

  task automatic t_reset();
    chk(sd_cs_n == 2'b11, "R12 cs", sd_cs_n, 3);
    chk(sd_cke == 1'b1 && req_ready == 1'b1, "R12 cke/ready", {sd_cke, req_ready}, 3);
    chk(sd_dqm == 4'hF && !rd_valid && !wr_beat, "R12 dqm/strobes", {sd_dqm, rd_valid, wr_beat}, 8'h3C);
  endtask

  task automatic t_read(input logic [2:0] men, input logic wide, input logic sp);
    int first, cnt;
    logic [1:0] ecs;
    logic [3:0] edqm;
    bit dq_ok, pre_ok;
    cfg_mem_en = men; cfg_wide = wide; cfg_burst_wr = 1'b0;
    issue(2'd0, sp, 2'd1, 12'h3A5, 9'h05C, 4'hF);
    ecs  = sp ? 2'b01 : 2'b10;
    edqm = wide ? 4'h0 : 4'hC;
    chk(t_cmd[0] == 3'b011 && t_cs[0] == ecs, "R2 ACTV", {t_cmd[0], t_cs[0]}, {3'b011, ecs});
    chk(t_addr[0] == 12'h3A5 && t_ba[0] == 2'd1, "R2 row/bank", t_addr[0], 12'h3A5);
    chk(t_cs[1] == 2'b11, "R8 deselect gap", t_cs[1], 3);
    chk(t_cmd[2] == 3'b101 && t_cs[2] == ecs && t_addr[2] == 12'h45C, "R2 READA",
        {t_cmd[2], t_addr[2]}, {3'b101, 12'h45C});
    first = -1; cnt = 0; dq_ok = 1; pre_ok = 1;
    for (int k = 0; k < 24; k++) begin
      if (t_rv[k]) begin
        if (first < 0) first = k;
        cnt++;
        if (t_dqm[k] != edqm || t_cs[k] != ecs) dq_ok = 0;
      end else if (t_dqm[k] != 4'hF) pre_ok = 0;
    end
    chk(first == 4, "R3 read latency", first, 4);
    chk(cnt == (wide ? 4 : 8), "R4 read burst length", cnt, wide ? 4 : 8);
    chk(dq_ok, wide ? "R6 read lanes" : "R7 read lanes", 0, edqm);
    chk(pre_ok, "R8 dqm idle", 0, 15);
  endtask

  task automatic t_write(input logic wide, input logic bw, input logic [3:0] be,
                         input logic [3:0] edqm, input int en);
    int first, cnt;
    bit dq_ok;
    cfg_mem_en = 3'b100; cfg_wide = wide; cfg_burst_wr = bw;
    issue(2'd1, 1'b0, 2'd2, 12'h011, 9'h1F0, be);
    chk(t_cmd[2] == 3'b100 && t_addr[2] == 12'h5F0, "R2 WRITA", {t_cmd[2], t_addr[2]}, {3'b100, 12'h5F0});
    first = -1; cnt = 0; dq_ok = 1;
    for (int k = 0; k < 24; k++) begin
      if (t_wb[k]) begin
        if (first < 0) first = k;
        cnt++;
        if (t_dqm[k] != edqm || t_cs[k] != 2'b10) dq_ok = 0;
      end
    end
    chk(first == 2 && cnt == en, "R5 write beats", {first[7:0], cnt[7:0]}, {8'd2, en[7:0]});
    chk(dq_ok, wide ? "R6 write lanes" : "R7 write lanes", 0, edqm);
  endtask

  task automatic t_unmapped(input logic [2:0] men, input logic sp);
    bit quiet;
    cfg_mem_en = men;
    issue(2'd0, sp, 2'd0, 12'h001, 9'h002, 4'hF);
    quiet = 1;
    for (int k = 0; k < 24; k++)
      if (t_cs[k] != 2'b11 || t_rv[k]) quiet = 0;
    chk(quiet, "R1 unmapped space silent", 0, 1);
  endtask

  task automatic t_refresh();
    cfg_mem_en = 3'b101;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    refresh_req = 1'b1;
    @(negedge clk);
    refresh_req = 1'b0;
    chk(req_ready == 1'b0, "R9 ready drops", req_ready, 0);
    req_valid = 1'b1; req_op = 2'd0; req_space = 1'b0;
    @(negedge clk);
    capture(0, 1);
    req_valid = 1'b0;
    @(negedge clk);
    capture(1, 8);
    chk(t_cmd[0] == 3'b010 && t_cs[0] == 2'b00 && t_addr[0][10], "R9 PALL first",
        {t_cmd[0], t_cs[0]}, {3'b010, 2'b00});
    chk(t_cmd[2] == 3'b001 && t_cs[2] == 2'b00 && t_cke[2], "R9 REF", {t_cmd[2], t_cke[2]}, {3'b001, 1'b1});
    chk(t_rdy[5] == 1'b0 && t_rdy[6] == 1'b1, "R9 ready return", {t_rdy[5], t_rdy[6]}, 1);
  endtask

  task automatic t_self();
    cfg_mem_en = 3'b101;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    self_req = 1'b1;
    @(negedge clk);
    capture(0, 8);
    self_req = 1'b0;
    @(negedge clk);
    capture(8, 8);
    chk(t_cmd[0] == 3'b010 && t_cs[0] == 2'b00, "R10 PALL", {t_cmd[0], t_cs[0]}, {3'b010, 2'b00});
    chk(t_cmd[2] == 3'b001 && t_cke[2] == 1'b0 && t_cke[1] == 1'b1, "R10 SELF entry",
        {t_cmd[2], t_cke[1], t_cke[2]}, {3'b001, 2'b10});
    chk(t_cke[7] == 1'b0 && t_cs[5] == 2'b11 && t_rdy[6] == 1'b0, "R10 held low",
        {t_cke[7], t_cs[5], t_rdy[6]}, 6);
    chk(t_cke[8] == 1'b1, "R10 exit cke", t_cke[8], 1);
    chk(t_rdy[11] == 1'b0 && t_rdy[12] == 1'b1, "R10 exit wait", {t_rdy[11], t_rdy[12]}, 1);
  endtask

  task automatic t_mrs();
    cfg_mem_en = 3'b101;
    issue(2'd2, 1'b0, 2'd0, 12'h032, 9'h000, 4'hF);
    chk(t_cmd[0] == 3'b000 && t_cs[0] == 2'b00 && t_addr[0] == 12'h032, "R11 MRS",
        {t_cmd[0], t_cs[0], t_addr[0]}, {3'b000, 2'b00, 12'h032});
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_read(3'b001, 1'b0, 1'b1);
    t_read(3'b100, 1'b1, 1'b0);
    t_read(3'b101, 1'b1, 1'b1);
    t_read(3'b101, 1'b0, 1'b0);
    t_write(1'b1, 1'b0, 4'b0001, 4'b0111, 1);
    t_write(1'b1, 1'b1, 4'b1000, 4'b1110, 4);
    t_write(1'b0, 1'b1, 4'b0001, 4'b1101, 8);
    t_write(1'b0, 1'b0, 4'b0010, 4'b1110, 1);
    t_unmapped(3'b001, 1'b0);
    t_unmapped(3'b100, 1'b1);
    t_unmapped(3'b000, 1'b1);
    t_refresh();
    t_self();
    t_mrs();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule